// File: doc/BRIEF.md
# Receive FIFO Watermark Bus Arbiter

This block decides which of two DMA engines, receive or transmit, is given the shared bus master at each arbitration point. The arbitration point is marked by a one-cycle strobe from the bus protocol engine. The grant comes out one cycle after the strobe, as a one-cycle pulse on exactly one of two grant lines, or on neither when nobody is requesting. The bus protocol engine itself lies outside this block.

Priority follows the fill level of the receive FIFO and uses hysteresis. When watermark arbitration is switched on, a two-state machine moves from `S_NORMAL` to `S_RX_URGENT` once the fill level reaches the high watermark. In `S_RX_URGENT` a receive request always wins. The machine returns to `S_NORMAL` only when the fill level has drained to the low watermark, or when the feature is switched off. Each watermark is a 3-bit count of eighths of the FIFO depth. Whenever the machine is in `S_NORMAL`, competing requests take turns round-robin.

The block also gives the length of the bus burst that is allowed. Three capability bits each permit one burst size. A 2-bit cap field limits the burst to a byte total, which is converted into beats of the bus width. The output is the largest permitted burst that fits under the cap.

Top module: `rxfifo_arb`

## Requirements
- R1: After reset both grant lines are low, the machine is in `S_NORMAL`, and the round-robin pointer is set so that the first tie after reset goes to receive.
- R2: A grant pulse appears only in the cycle after `arb_go` is high, and only to a requester sampled in that `arb_go` cycle. No grant appears without `arb_go` or without a request, and at most one grant line is high at a time.
- R3: In `S_NORMAL`, when both engines request, the grant goes to the engine that did not receive the most recent grant, so repeated ties alternate rx, tx, rx.
- R4: A lone requester is granted at any arbitration point, whatever the state.
- R5: With `thr_en`=1, the transition `S_NORMAL`->`S_RX_URGENT` happens when `fifo_lvl` >= `hi_mark`*DEPTH/8. From then on, a receive request wins every arbitration point.
- R6: The transition `S_RX_URGENT`->`S_NORMAL` happens when `fifo_lvl` <= `lo_mark`*DEPTH/8. Between the two marks the current state holds, which gives hysteresis.
- R7: With `thr_en`=0 the machine leaves `S_RX_URGENT` and never enters it, so ties alternate even with a full FIFO.
- R8: In `S_RX_URGENT`, a transmit request is still granted when receive is not requesting.
- R9: `burst_beats` is the largest enabled size that does not exceed the cap. Capability bit 0 enables 4 beats, bit 1 enables 8 beats and bit 2 enables 16 beats. The `max_burst` encoding works as follows: 0 means unlimited, 1 is reserved and also means unlimited, 2 allows 128 bytes and 3 allows 256 bytes. Each beat is BUS_BYTES bytes, which is 16 by default, giving caps of 8 and 16 beats.
- R10: If no enabled size fits under the cap, including the case where no capability bit is set, `burst_beats` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_go | input | 1 | Arbitration point strobe |
| rx_req | input | 1 | Receive DMA requests the bus |
| tx_req | input | 1 | Transmit DMA requests the bus |
| fifo_lvl | input | LVL_W (7) | Receive FIFO fill level in words |
| thr_en | input | 1 | Enables watermark priority |
| hi_mark | input | 3 | High watermark in eighths of DEPTH |
| lo_mark | input | 3 | Low watermark in eighths of DEPTH |
| max_burst | input | 2 | Burst cap encoding |
| burst_caps | input | 3 | Enabled burst sizes: 4, 8 and 16 beats |
| gnt_rx | output | 1 | One-cycle grant to receive DMA |
| gnt_tx | output | 1 | One-cycle grant to transmit DMA |
| burst_beats | output | BEAT_W (5) | Permitted burst length in beats |

## Verification
Ties are applied at a low fill level to show round-robin alternation. The same ties are then applied after the level crosses the high mark, where receive must win twice in a row, so the two kinds of arbitration can be told apart. Levels between the marks, exactly at the low mark and one above it are used to separate correct hysteresis from a plain single-threshold compare. A full FIFO with the feature disabled checks that the enable really gates the priority. The burst output is checked across every cap encoding, with capability mixes where the cap removes the largest size and with mixes where nothing fits.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
    typedef enum logic {
        S_NORMAL    = 1'b0,
        S_RX_URGENT = 1'b1
    } pri_state_t;
endpackage

// File: rtl/rfa_hyst_fsm.sv
module rfa_hyst_fsm
    import rfa_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_en,
    input  logic [LVL_W-1:0] fifo_lvl,
    input  logic [2:0]       hi_mark,
    input  logic [2:0]       lo_mark,
    output pri_state_t       state,
    output logic             rx_pri
);
    localparam int EIGHTH = DEPTH / 8;

    logic [LVL_W+2:0] hi_lvl, lo_lvl, lvl_ext;
    pri_state_t       state_nx;

    assign hi_lvl  = (LVL_W+3)'(hi_mark) * (LVL_W+3)'(EIGHTH);
    assign lo_lvl  = (LVL_W+3)'(lo_mark) * (LVL_W+3)'(EIGHTH);
    assign lvl_ext = (LVL_W+3)'(fifo_lvl);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_NORMAL:    if (thr_en && lvl_ext >= hi_lvl) state_nx = S_RX_URGENT;
            S_RX_URGENT: if (!thr_en || lvl_ext <= lo_lvl) state_nx = S_NORMAL;
            default:     state_nx = S_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_NORMAL;
        else        state <= state_nx;
    end

    assign rx_pri = (state == S_RX_URGENT);
endmodule

// File: rtl/rfa_rr_pick.sv
module rfa_rr_pick (
    input  logic rx_req,
    input  logic tx_req,
    input  logic rx_pri,
    input  logic last_rx,
    output logic pick_rx,
    output logic pick_tx
);
    always_comb begin
        pick_rx = 1'b0;
        pick_tx = 1'b0;
        if (rx_req && tx_req) begin
            if (rx_pri || !last_rx) pick_rx = 1'b1;
            else                    pick_tx = 1'b1;
        end else begin
            pick_rx = rx_req;
            pick_tx = tx_req;
        end
    end
endmodule

// File: rtl/rfa_burst_sel.sv
module rfa_burst_sel #(
    parameter int BUS_BYTES = 16,
    parameter int NCAP      = 3,
    parameter int BEAT_W    = $clog2((4 << (NCAP - 1)) + 1)
) (
    input  logic [1:0]      max_burst,
    input  logic [NCAP-1:0] burst_caps,
    output logic [BEAT_W-1:0] burst_beats
);
    localparam int LIM_128 = 128 / BUS_BYTES;
    localparam int LIM_256 = 256 / BUS_BYTES;
    localparam int LIM_ANY = 1 << 20;

    int          limit;
    logic [NCAP-1:0] fits;

    always_comb begin
        unique case (max_burst)
            2'd2:    limit = LIM_128;
            2'd3:    limit = LIM_256;
            default: limit = LIM_ANY;
        endcase
    end

    for (genvar i = 0; i < NCAP; i++) begin : g_fit
        assign fits[i] = burst_caps[i] && ((4 << i) <= limit);
    end

    always_comb begin
        burst_beats = BEAT_W'(1);
        for (int i = 0; i < NCAP; i++) begin
            if (fits[i]) burst_beats = BEAT_W'(4 << i);
        end
    end
endmodule

// File: rtl/rxfifo_arb.sv
module rxfifo_arb
    import rfa_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int BUS_BYTES = 16,
    parameter int NCAP      = 3,
    parameter int LVL_W     = $clog2(DEPTH + 1),
    parameter int BEAT_W    = $clog2((4 << (NCAP - 1)) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_go,
    input  logic              rx_req,
    input  logic              tx_req,
    input  logic [LVL_W-1:0]  fifo_lvl,
    input  logic              thr_en,
    input  logic [2:0]        hi_mark,
    input  logic [2:0]        lo_mark,
    input  logic [1:0]        max_burst,
    input  logic [NCAP-1:0]   burst_caps,
    output logic              gnt_rx,
    output logic              gnt_tx,
    output logic [BEAT_W-1:0] burst_beats
);
    pri_state_t pri_state;
    logic       rx_pri, last_rx, pick_rx, pick_tx;

    rfa_hyst_fsm #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_en   (thr_en),
        .fifo_lvl (fifo_lvl),
        .hi_mark  (hi_mark),
        .lo_mark  (lo_mark),
        .state    (pri_state),
        .rx_pri   (rx_pri)
    );

    rfa_rr_pick u_pick (
        .rx_req  (rx_req),
        .tx_req  (tx_req),
        .rx_pri  (rx_pri),
        .last_rx (last_rx),
        .pick_rx (pick_rx),
        .pick_tx (pick_tx)
    );

    rfa_burst_sel #(.BUS_BYTES(BUS_BYTES), .NCAP(NCAP), .BEAT_W(BEAT_W)) u_burst (
        .max_burst   (max_burst),
        .burst_caps  (burst_caps),
        .burst_beats (burst_beats)
    );

    // Output process: grant pulses and round-robin pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_rx  <= 1'b0;
            gnt_tx  <= 1'b0;
            last_rx <= 1'b0;
        end else begin
            gnt_rx <= arb_go && pick_rx;
            gnt_tx <= arb_go && pick_tx;
            if (arb_go && pick_rx)      last_rx <= 1'b1;
            else if (arb_go && pick_tx) last_rx <= 1'b0;
        end
    end
endmodule

// File: rtl/rxfifo_arb_chk.sv
module rxfifo_arb_chk
    import rfa_pkg::*;
#(
    parameter int BEAT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arb_go,
    input logic              rx_req,
    input logic              tx_req,
    input logic              thr_en,
    input logic              gnt_rx,
    input logic              gnt_tx,
    input logic [BEAT_W-1:0] burst_beats,
    input pri_state_t        pri_state
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_rx, gnt_tx})); // R2
    AST_RX_GNT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_go && rx_req) |=> !gnt_rx); // R2
    AST_TX_GNT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_go && tx_req) |=> !gnt_tx); // R2
    AST_LONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_go && (rx_req || tx_req)) |=> (gnt_rx || gnt_tx)); // R4
    AST_URGENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_state == S_RX_URGENT && arb_go && rx_req) |=> gnt_rx); // R5
    AST_DISABLED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_en |=> pri_state == S_NORMAL); // R7
    AST_BURST_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(burst_beats)); // R9
endmodule

bind rxfifo_arb rxfifo_arb_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arb_go      (arb_go),
    .rx_req      (rx_req),
    .tx_req      (tx_req),
    .thr_en      (thr_en),
    .gnt_rx      (gnt_rx),
    .gnt_tx      (gnt_tx),
    .burst_beats (burst_beats),
    .pri_state   (pri_state)
);

// File: tb/rxfifo_arb_tb.sv
`timescale 1ns/1ps
module rxfifo_arb_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_go = 1'b0, rx_req = 1'b0, tx_req = 1'b0;
    logic [6:0] fifo_lvl = '0;
    logic       thr_en = 1'b1;
    logic [2:0] hi_mark = 3'd6, lo_mark = 3'd2;
    logic [1:0] max_burst = 2'd0;
    logic [2:0] burst_caps = 3'b111;
    logic       gnt_rx, gnt_tx;
    logic [4:0] burst_beats;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxfifo_arb u_dut (
        .clk(clk), .rst_n(rst_n), .arb_go(arb_go), .rx_req(rx_req),
        .tx_req(tx_req), .fifo_lvl(fifo_lvl), .thr_en(thr_en),
        .hi_mark(hi_mark), .lo_mark(lo_mark), .max_burst(max_burst),
        .burst_caps(burst_caps), .gnt_rx(gnt_rx), .gnt_tx(gnt_tx),
        .burst_beats(burst_beats)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One arbitration point; gnt code: 0 none, 1 rx, 2 tx
    task automatic arb(input logic r, input logic t, input string req, input int exp);
        @(negedge clk);
        rx_req = r; tx_req = t; arb_go = 1'b1;
        @(negedge clk);
        arb_go = 1'b0;
        check(req, {30'd0, gnt_tx, gnt_rx}, exp);
    endtask

    task automatic set_lvl(input int v);
        @(negedge clk);
        fifo_lvl = 7'(v);
    endtask

    task automatic t_reset;
        check("R1 gnt after reset", {30'd0, gnt_tx, gnt_rx}, 0);
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        rx_req = 1'b1; tx_req = 1'b1;
        @(negedge clk);
        check("R2 no strobe", {30'd0, gnt_tx, gnt_rx}, 0);
        arb(1'b0, 1'b0, "R2 no request", 0);
    endtask

    task automatic t_round_robin;
        set_lvl(0);
        arb(1'b1, 1'b1, "R3 tie 1 (and R1 first to rx)", 1);
        arb(1'b1, 1'b1, "R3 tie 2", 2);
        arb(1'b1, 1'b1, "R3 tie 3", 1);
    endtask

    task automatic t_lone;
        arb(1'b0, 1'b1, "R4 tx alone", 2);
        arb(1'b1, 1'b0, "R4 rx alone", 1);
    endtask

    task automatic t_hysteresis;
        set_lvl(47);
        arb(1'b1, 1'b1, "R5 below high mark ties alternate", 2);
        set_lvl(48);
        arb(1'b1, 1'b1, "R5 at high mark", 1);
        arb(1'b1, 1'b1, "R5 rx keeps winning", 1);
        set_lvl(30);
        arb(1'b1, 1'b1, "R6 between marks", 1);
        set_lvl(17);
        arb(1'b1, 1'b1, "R6 one above low mark", 1);
        set_lvl(16);
        arb(1'b1, 1'b1, "R6 at low mark back to normal", 2);
        set_lvl(30);
        arb(1'b1, 1'b1, "R6 rising between marks stays normal", 1);
        arb(1'b1, 1'b1, "R6 rising between marks alternates", 2);
    endtask

    task automatic t_urgent_tx;
        set_lvl(60);
        arb(1'b0, 1'b1, "R8 tx alone while urgent", 2);
        arb(1'b1, 1'b1, "R8 tie while urgent", 1);
    endtask

    task automatic t_disabled;
        @(negedge clk);
        thr_en = 1'b0;
        fifo_lvl = 7'd64;
        @(negedge clk);
        arb(1'b1, 1'b1, "R7 disabled full tie 1", 2);
        arb(1'b1, 1'b1, "R7 disabled full tie 2", 1);
        arb(1'b1, 1'b1, "R7 disabled full tie 3", 2);
        @(negedge clk);
        thr_en = 1'b1;
        fifo_lvl = 7'd0;
    endtask

    task automatic burst(input logic [1:0] m, input logic [2:0] c, input string req, input int exp);
        @(negedge clk);
        max_burst = m; burst_caps = c;
        #1;
        check(req, int'(burst_beats), exp);
    endtask

    task automatic t_burst;
        burst(2'd0, 3'b111, "R9 unlimited all caps", 16);
        burst(2'd1, 3'b111, "R9 reserved code unlimited", 16);
        burst(2'd2, 3'b111, "R9 128-byte cap", 8);
        burst(2'd3, 3'b111, "R9 256-byte cap", 16);
        burst(2'd2, 3'b011, "R9 cap 8 caps 4,8", 8);
        burst(2'd0, 3'b001, "R9 only 4", 4);
        burst(2'd3, 3'b101, "R9 caps 4,16 at 256", 16);
        burst(2'd2, 3'b101, "R9 caps 4,16 at 128", 4);
        burst(2'd2, 3'b100, "R10 only 16 over cap", 1);
        burst(2'd0, 3'b000, "R10 no caps", 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_no_strobe();
        t_round_robin();
        t_lone();
        t_hysteresis();
        t_urgent_tx();
        t_disabled();
        t_burst();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule